// File: doc/BRIEF.md
# HDB3 Line Encoder

This block turns a serial NRZ bit stream into the HDB3 pseudo-ternary line code. The code is carried on two unipolar rails, one per mark polarity. Ones become marks that alternate in polarity. Every run of four zeros is replaced by a substitution pattern: either `000V` or `B00V`. The pattern is chosen so that consecutive violations alternate in polarity and the line carries no DC component.

Input bits are sampled on the falling edge of the encoder clock and pass through a short window of falling-edge stages. The window gives the encoder enough lookahead to rewrite the first zero of a run once the fourth zero has arrived. A mark appears on its rail as a pulse gated to the clock high phase. The rail output is therefore return-to-zero, with a pulse width equal to the clock high time.

A synchronous reset puts the polarity trackers into a fixed state. As a result, the encoding of any stream after reset is fully deterministic.

Top module: `hdb3_line_encoder`

## Requirements
- R1: Each input one is sent as a mark whose polarity is the opposite of the previous mark. The first mark after reset is positive, on `rail_pos`.
- R2: When four consecutive input zeros occur, the fourth zero is sent as a violation, which is a mark with the same polarity as the previous mark.
- R3: The first zero of such a run is sent as a normal mark (polarity opposite the previous mark) exactly when the previous mark and the previous violation have the same polarity; otherwise it stays a zero. As a result, successive violations always alternate in polarity.
- R4: Runs of one to three zeros are sent as zeros, unchanged. After a substitution, zero counting starts again from the next input bit.
- R5: The input is sampled on the falling edge of `clk`. The symbol for a bit sampled at one falling edge is shown on the rails starting at the rising edge 4.5 clock periods later, for the default run length of 4.
- R6: A rail is high only during the clock high phase of the cycle in which it sends a mark. Both rails are low during every clock low phase, and both are low for a zero symbol.
- R7: `rail_pos` and `rail_neg` are never high at the same time.
- R8: `rst` is active high and is sampled on the falling edge of `clk`. While reset is asserted, and for the 4.5 periods that follow it, both rails stay low. Reset sets both the last-mark and the last-violation polarity to negative, so that a stream starting with four zeros is encoded as `+00+`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Encoder clock; input sampled and state updated on its falling edge |
| rst | input | 1 | Synchronous reset, active high |
| nrz_in | input | 1 | Serial NRZ data to encode |
| rail_pos | output | 1 | Positive-mark rail, pulses during the clock high phase |
| rail_neg | output | 1 | Negative-mark rail, pulses during the clock high phase |

## Verification
The bench targets the choice between `B00V` and `000V`.

- A run of zeros directly after reset, or after an even number of marks, needs the leading `B`. A design that tested the tracker parity the wrong way would show two violations of the same polarity.
- A long stretch of zeros checks that counting restarts after each substitution. A design that carried zeros across a substitution would insert a violation early or miss one.
- Every clock cycle is checked in both its high and low phases. A pipeline that is one stage short or long, or a rail held for a whole period, fails on the first mark.

// File: rtl/hdb3_enc_pkg.sv
package hdb3_enc_pkg;

    // Symbol classes held in the lookahead window
    typedef enum logic [2:0] {
        SYM_FILL = 3'd0,   // reset filler, never part of a zero run
        SYM_ZERO = 3'd1,   // plain input zero
        SYM_ONE  = 3'd2,   // plain input one
        SYM_HEAD = 3'd3,   // first zero of a substituted run
        SYM_VIOL = 3'd4    // last zero of a substituted run
    } sym_e;

    // Polarity encoding: 1 = positive mark, 0 = negative mark
    localparam logic POL_POS = 1'b1;
    localparam logic POL_NEG = 1'b0;

endpackage

// File: rtl/hdb3_window.sv
module hdb3_window
    import hdb3_enc_pkg::*;
#(
    parameter int RUN_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output sym_e sym_o
);

    localparam int LAST = RUN_LEN - 1;

    typedef struct packed {
        sym_e [RUN_LEN-1:0] slot;
    } win_t;

    win_t win_q, win_d;
    logic prior_zero;
    logic run_hit;
    logic win_all_zero;

    // Next window: shift in new bit, rewrite head and tail on a full zero run
    always_comb begin
        win_d      = win_q;
        prior_zero = 1'b1;
        for (int k = 0; k < LAST; k++) begin
            if (win_q.slot[k] != SYM_ZERO) begin
                prior_zero = 1'b0;
            end
        end
        run_hit = !bit_in && prior_zero;

        for (int k = LAST; k > 0; k--) begin
            win_d.slot[k] = win_q.slot[k-1];
        end
        win_d.slot[0] = bit_in ? SYM_ONE : SYM_ZERO;

        if (run_hit) begin
            win_d.slot[0]    = SYM_VIOL;
            win_d.slot[LAST] = SYM_HEAD;
        end

        if (rst) begin
            for (int k = 0; k < RUN_LEN; k++) begin
                win_d.slot[k] = SYM_FILL;
            end
        end
    end

    always_ff @(negedge clk) begin
        win_q <= win_d;
    end

    assign sym_o = win_q.slot[LAST];

    // Independent scan of the registered window for the assertion below
    always_comb begin
        win_all_zero = 1'b1;
        for (int k = 0; k < RUN_LEN; k++) begin
            if (win_q.slot[k] != SYM_ZERO) begin
                win_all_zero = 1'b0;
            end
        end
    end

    // R4
    no_plain_run_chk: assert property (@(negedge clk) disable iff (rst)
        !win_all_zero);

endmodule

// File: rtl/hdb3_polarity.sv
module hdb3_polarity
    import hdb3_enc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  sym_e sym_i,
    output logic mark_pos_o,
    output logic mark_neg_o
);

    typedef struct packed {
        logic last_mark;
        logic last_viol;
        logic mark_pos;
        logic mark_neg;
    } pol_t;

    pol_t st_q, st_d;
    logic emit;
    logic pol;

    always_comb begin
        st_d = st_q;
        emit = 1'b0;
        pol  = ~st_q.last_mark;

        case (sym_i)
            SYM_ONE: begin
                emit = 1'b1;
            end
            SYM_HEAD: begin
                emit = (st_q.last_mark == st_q.last_viol);
            end
            SYM_VIOL: begin
                emit           = 1'b1;
                pol            = st_q.last_mark;
                st_d.last_viol = st_q.last_mark;
            end
            default: begin
                emit = 1'b0;
            end
        endcase

        if (emit) begin
            st_d.last_mark = pol;
        end
        st_d.mark_pos = emit && (pol == POL_POS);
        st_d.mark_neg = emit && (pol == POL_NEG);

        if (rst) begin
            st_d.last_mark = POL_NEG;
            st_d.last_viol = POL_NEG;
            st_d.mark_pos  = 1'b0;
            st_d.mark_neg  = 1'b0;
        end
    end

    always_ff @(negedge clk) begin
        st_q <= st_d;
    end

    assign mark_pos_o = st_q.mark_pos;
    assign mark_neg_o = st_q.mark_neg;

    // R7
    rails_exclusive_chk: assert property (@(negedge clk) disable iff (rst)
        !(st_q.mark_pos && st_q.mark_neg));

    // R3
    viol_alternate_chk: assert property (@(negedge clk) disable iff (rst)
        (sym_i == SYM_VIOL) |-> (st_q.last_mark != st_q.last_viol));

    // R8
    reset_quiet_chk: assert property (@(negedge clk) disable iff (rst)
        $past(rst) |-> (!st_q.mark_pos && !st_q.mark_neg));

endmodule

// File: rtl/hdb3_rail_gate.sv
module hdb3_rail_gate (
    input  logic clk,
    input  logic mark_pos,
    input  logic mark_neg,
    output logic rail_pos,
    output logic rail_neg
);

    // Return-to-zero shaping: a mark is visible only while the clock is high
    assign rail_pos = mark_pos & clk;
    assign rail_neg = mark_neg & clk;

endmodule

// File: rtl/hdb3_line_encoder.sv
module hdb3_line_encoder
    import hdb3_enc_pkg::*;
#(
    parameter int RUN_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic nrz_in,
    output logic rail_pos,
    output logic rail_neg
);

    sym_e oldest_sym;
    logic mark_pos;
    logic mark_neg;

    hdb3_window #(.RUN_LEN(RUN_LEN)) window_i (
        .clk    (clk),
        .rst    (rst),
        .bit_in (nrz_in),
        .sym_o  (oldest_sym)
    );

    hdb3_polarity polarity_i (
        .clk        (clk),
        .rst        (rst),
        .sym_i      (oldest_sym),
        .mark_pos_o (mark_pos),
        .mark_neg_o (mark_neg)
    );

    hdb3_rail_gate gate_i (
        .clk      (clk),
        .mark_pos (mark_pos),
        .mark_neg (mark_neg),
        .rail_pos (rail_pos),
        .rail_neg (rail_neg)
    );

endmodule

// File: tb/hdb3_line_encoder_tb_top.sv
module hdb3_line_encoder_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nrz_in = 1'b0;
    logic rail_pos;
    logic rail_neg;

    int n_checks = 0;
    int n_fail   = 0;
    int bits[128];
    int exp_sym[128];

    always #10 clk = ~clk;

    hdb3_line_encoder dut_i (
        .clk      (clk),
        .rst      (rst),
        .nrz_in   (nrz_in),
        .rail_pos (rail_pos),
        .rail_neg (rail_neg)
    );

    task automatic check(string tag, int idx, logic got_p, logic got_n, logic exp_p, logic exp_n);
        n_checks++;
        if (got_p !== exp_p || got_n !== exp_n) begin
            n_fail++;
            $display("FAIL %s symbol %0d: actual pos=%b neg=%b, expected pos=%b neg=%b",
                     tag, idx, got_p, got_n, exp_p, exp_n);
        end
    endtask

    // Reference HDB3 coder over the whole stream (reset state: both trackers negative)
    task automatic build_expected(int total);
        int last_m = -1;
        int last_v = -1;
        int zeros  = 0;
        for (int i = 0; i < total; i++) begin
            if (bits[i] != 0) begin
                last_m     = -last_m;
                exp_sym[i] = last_m;
                zeros      = 0;
            end else begin
                exp_sym[i] = 0;
                zeros++;
                if (zeros == 4) begin
                    if (last_m == last_v) begin
                        last_m         = -last_m;
                        exp_sym[i - 3] = last_m;
                    end
                    exp_sym[i] = last_m;
                    last_v     = last_m;
                    zeros      = 0;
                end
            end
        end
    endtask

    task automatic run_seq(string tag, int len);
        int total = len + 5;
        for (int i = len; i < total; i++) bits[i] = 0;
        build_expected(total);
        @(posedge clk); #1;
        rst = 1'b1;
        nrz_in = 1'b0;
        repeat (2) @(posedge clk);
        for (int i = 0; i < total; i++) begin
            int j;
            @(posedge clk); #1;
            rst = 1'b0;
            nrz_in = (bits[i] != 0);
            #4;
            j = i - 5;
            if (j < 0) begin
                check("R8 reset quiet", j, rail_pos, rail_neg, 1'b0, 1'b0);
            end else if (j < len) begin
                check({tag, "/R5"}, j, rail_pos, rail_neg, exp_sym[j] == 1, exp_sym[j] == -1);
            end
            check("R7 exclusive", j, rail_pos && rail_neg, 1'b0, 1'b0, 1'b0);
            #10;
            check("R6 low phase", j, rail_pos, rail_neg, 1'b0, 1'b0);
        end
    endtask

    task automatic scen_all_ones();
        for (int i = 0; i < 16; i++) bits[i] = 1;
        run_seq("R1 all ones", 16);
    endtask

    task automatic scen_leading_run();
        int pat[14] = '{0,0,0,0,1,1,0,0,0,0,1,0,0,1};
        for (int i = 0; i < 14; i++) bits[i] = pat[i];
        run_seq("R3 leading run B00V", 14);
    endtask

    task automatic scen_odd_marks();
        int pat[16] = '{1,0,0,0,0,1,0,0,0,0,1,1,1,0,0,0};
        for (int i = 0; i < 16; i++) bits[i] = pat[i];
        run_seq("R2 000V after odd marks", 16);
    endtask

    task automatic scen_short_runs();
        int pat[14] = '{1,0,1,0,0,1,0,0,0,1,0,0,0,1};
        for (int i = 0; i < 14; i++) bits[i] = pat[i];
        run_seq("R4 short runs", 14);
    endtask

    task automatic scen_long_zeros();
        bits[0] = 1;
        for (int i = 1; i < 30; i++) bits[i] = 0;
        run_seq("R3 violations alternate", 30);
    endtask

    task automatic scen_mixed();
        logic [15:0] lfsr = 16'hACE1;
        for (int i = 0; i < 80; i++) begin
            bits[i] = (lfsr[0] && lfsr[3]) ? 1 : 0;
            lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
        end
        run_seq("R2 mixed stream", 80);
    endtask

    initial begin
        #(20 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung, expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        scen_all_ones();
        scen_leading_run();
        scen_odd_marks();
        scen_short_runs();
        scen_long_zeros();
        scen_mixed();
        repeat (2) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule